// File: doc/BRIEF.md
# Quadrant Nametable Source Selector

This block sits between a video fetch engine and the memories behind a four-quadrant nametable space. Each video access carries a quadrant index and a 10-bit offset inside that quadrant. A mapping byte assigns every quadrant to one of four sources. Two of the sources are pages of an external RAM. For those, the block returns a RAM enable and the single page-select address line. The other two are served by the block itself: a 1 KB on-chip extended RAM, and a fill generator that needs no memory.

The fill generator returns a constant tile number for the tile area of a quadrant. For the last 64 bytes of the quadrant it returns an attribute byte built from one 2-bit colour code repeated four times.

A CPU register bus writes the mapping byte, the fill tile and the fill attribute. The same bus reads and writes the extended RAM through a 1 KB window.

Top module: `nt_quad_select`

## Requirements
- R1: After reset the mapping byte, fill tile and fill attribute are zero, so every quadrant selects external page 0, and `vid_rvalid`, `vid_rdata` and `cpu_rdata` are zero.
- R2: The quadrant index is `vid_addr[11:10]`, and quadrant n takes its 2-bit source code from mapping byte bits [2n+1:2n].
- R3: Codes 0 and 1 raise `vid_int_en` in the same cycle as the access, with `vid_int_a10` equal to the code's low bit. In the next cycle `vid_rvalid` is 0 and `vid_rdata` is 0x00.
- R4: Code 2 returns, one cycle after the access, `vid_rvalid`=1 and the extended-RAM byte at offset `vid_addr[9:0]`.
- R5: Code 3 at offsets 0x000 to 0x3BF returns, one cycle later, `vid_rvalid`=1 and the fill tile value.
- R6: Code 3 at offsets 0x3C0 to 0x3FF returns, one cycle later, `vid_rvalid`=1 and the low two bits of the fill attribute repeated in bit pairs [1:0], [3:2], [5:4] and [7:6].
- R7: Codes 2 and 3 never raise `vid_int_en`, and `vid_int_a10` is 0 whenever `vid_int_en` is 0.
- R8: A CPU write to 0x5C00 to 0x5FFF stores the byte at extended-RAM offset `cpu_addr[9:0]`. A CPU read there returns that byte on `cpu_rdata` one cycle later. A read outside the window returns 0x00, and a write outside the window and off the register addresses changes nothing.
- R9: The mapping byte is written at 0x5105, the fill tile at 0x5106 and the fill attribute at 0x5107. A video access in the same cycle as such a write uses the old value, and any later access uses the new one.
- R10: When the CPU writes an extended-RAM byte in the same cycle as a video read of that byte, the video read returns the old contents.
- R11: With `vid_rd_en` low, `vid_int_en` is 0, and `vid_rvalid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_rd_en | input | 1 | CPU read strobe |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Extended-RAM read data, one cycle after the read |
| vid_rd_en | input | 1 | Video access strobe |
| vid_addr | input | 12 | Quadrant index [11:10] and offset [9:0] |
| vid_int_en | output | 1 | External page RAM enable, same cycle |
| vid_int_a10 | output | 1 | External page select line, same cycle |
| vid_rvalid | output | 1 | The block itself returns the byte, one cycle after the access |
| vid_rdata | output | 8 | Byte from the extended RAM or the fill generator |

## Verification
A corrupted mapping field shows up in the same cycle on `vid_int_en` and `vid_int_a10`. In the following cycle it also shows up on `vid_rvalid` and `vid_rdata` for the quadrant that was hit. A wrong fill tile or fill attribute appears one cycle after the first fill access to the affected area. A bad extended-RAM byte appears on the first read of that offset from either side. The bench drives every quadrant and both fill areas with the mapping changed mid-stream, so any of these faults is caught within a cycle of the access that exposes it.

// File: rtl/nts_pkg.sv
package nts_pkg;

  localparam int NUM_QUAD = 4;
  localparam int QUAD_W   = $clog2(NUM_QUAD);

  typedef enum logic [1:0] {
    SRC_PAGE0 = 2'd0,
    SRC_PAGE1 = 2'd1,
    SRC_EXRAM = 2'd2,
    SRC_FILL  = 2'd3
  } nt_src_e;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_EXRAM = 2'd1,
    OWN_FILL  = 2'd2
  } own_sel_e;

endpackage

// File: rtl/nts_cfg_regs.sv
module nts_cfg_regs
  import nts_pkg::*;
#(
  parameter int                 AW        = 16,
  parameter logic [AW-1:0]      MAP_ADDR  = 16'h5105,
  parameter logic [AW-1:0]      TILE_ADDR = 16'h5106,
  parameter logic [AW-1:0]      ATTR_ADDR = 16'h5107
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         addr,
  input  logic [7:0]            wdata,
  output logic [2*NUM_QUAD-1:0] map_q,
  output logic [7:0]            tile_q,
  output logic [1:0]            attr_q
);

  localparam int MAP_W = 2 * NUM_QUAD;

  logic map_ce, tile_ce, attr_ce;
  logic [MAP_W-1:0] map_d;
  logic [7:0]       tile_d;
  logic [1:0]       attr_d;

  always_comb begin
    map_ce  = wr_en && (addr == MAP_ADDR);
    tile_ce = wr_en && (addr == TILE_ADDR);
    attr_ce = wr_en && (addr == ATTR_ADDR);
    map_d   = wdata[MAP_W-1:0];
    tile_d  = wdata;
    attr_d  = wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= '0;
      tile_q <= '0;
      attr_q <= '0;
    end else begin
      if (map_ce)  map_q  <= map_d;
      if (tile_ce) tile_q <= tile_d;
      if (attr_ce) attr_q <= attr_d;
    end
  end

endmodule

// File: rtl/nts_route.sv
module nts_route
  import nts_pkg::*;
(
  input  logic                  rd_en,
  input  logic [QUAD_W-1:0]     quad,
  input  logic [2*NUM_QUAD-1:0] map,
  output nt_src_e               src,
  output logic                  int_en,
  output logic                  int_a10
);

  nt_src_e code_arr [NUM_QUAD];

  for (genvar q = 0; q < NUM_QUAD; q++) begin : g_field
    assign code_arr[q] = nt_src_e'(map[2*q+1 -: 2]);
  end

  always_comb begin
    src     = code_arr[quad];
    int_en  = rd_en && ((src == SRC_PAGE0) || (src == SRC_PAGE1));
    int_a10 = int_en && (src == SRC_PAGE1);
  end

endmodule

// File: rtl/nts_exram.sv
module nts_exram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re_a,
  input  logic [AW-1:0] addr_a,
  output logic [7:0]    q_a,
  input  logic          re_b,
  input  logic [AW-1:0] addr_b,
  output logic [7:0]    q_b
);

  localparam int DEPTH = 2 ** AW;

  logic [7:0] mem [DEPTH];

  // Reads sample the array before this edge's write lands.
  always_ff @(posedge clk) begin
    if (we)   mem[waddr] <= wdata;
    if (re_a) q_a        <= mem[addr_a];
    if (re_b) q_b        <= mem[addr_b];
  end

endmodule

// File: rtl/nts_fill.sv
module nts_fill #(
  parameter int OFF_W      = 10,
  parameter int ATTR_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [OFF_W-1:0] offset,
  input  logic [7:0]       tile,
  input  logic [1:0]       attr,
  output logic [7:0]       q
);

  localparam logic [OFF_W-1:0] ATTR_START = OFF_W'((2 ** OFF_W) - ATTR_BYTES);

  logic [7:0] attr_byte;
  logic [7:0] fill_d;

  for (genvar f = 0; f < 4; f++) begin : g_rep
    assign attr_byte[2*f+1 -: 2] = attr;
  end

  always_comb begin
    fill_d = (offset >= ATTR_START) ? attr_byte : tile;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= fill_d;
  end

endmodule

// File: rtl/nt_quad_select.sv
module nt_quad_select
  import nts_pkg::*;
#(
  parameter int                CPU_AW     = 16,
  parameter int                EXRAM_AW   = 10,
  parameter int                ATTR_BYTES = 64,
  parameter logic [CPU_AW-1:0] EXRAM_BASE = 16'h5C00,
  parameter logic [CPU_AW-1:0] MAP_ADDR   = 16'h5105,
  parameter logic [CPU_AW-1:0] TILE_ADDR  = 16'h5106,
  parameter logic [CPU_AW-1:0] ATTR_ADDR  = 16'h5107
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_wr_en,
  input  logic                       cpu_rd_en,
  input  logic [CPU_AW-1:0]          cpu_addr,
  input  logic [7:0]                 cpu_wdata,
  output logic [7:0]                 cpu_rdata,
  input  logic                       vid_rd_en,
  input  logic [EXRAM_AW+QUAD_W-1:0] vid_addr,
  output logic                       vid_int_en,
  output logic                       vid_int_a10,
  output logic                       vid_rvalid,
  output logic [7:0]                 vid_rdata
);

  localparam int VID_AW = EXRAM_AW + QUAD_W;

  // reset: asserted at once, released after two edges
  logic [1:0] rst_sh;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_sync_n = rst_sh[1];

  // configuration
  logic [2*NUM_QUAD-1:0] map_q;
  logic [7:0]            tile_q;
  logic [1:0]            attr_q;

  nts_cfg_regs #(
    .AW(CPU_AW), .MAP_ADDR(MAP_ADDR), .TILE_ADDR(TILE_ADDR), .ATTR_ADDR(ATTR_ADDR)
  ) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(cpu_wr_en), .addr(cpu_addr),
    .wdata(cpu_wdata), .map_q(map_q), .tile_q(tile_q), .attr_q(attr_q)
  );

  // video side decode
  logic [QUAD_W-1:0]   quad;
  logic [EXRAM_AW-1:0] vid_off;
  nt_src_e             src;

  assign quad    = vid_addr[VID_AW-1 -: QUAD_W];
  assign vid_off = vid_addr[EXRAM_AW-1:0];

  nts_route u_route (
    .rd_en(vid_rd_en), .quad(quad), .map(map_q),
    .src(src), .int_en(vid_int_en), .int_a10(vid_int_a10)
  );

  // cpu window decode
  logic                cpu_in_win;
  logic                ex_we, cpu_re, vid_ex_re, fill_en;
  logic [EXRAM_AW-1:0] cpu_off;

  always_comb begin
    cpu_in_win = (cpu_addr[CPU_AW-1:EXRAM_AW] == EXRAM_BASE[CPU_AW-1:EXRAM_AW]);
    cpu_off    = cpu_addr[EXRAM_AW-1:0];
    ex_we      = cpu_wr_en && cpu_in_win && rst_sync_n;
    cpu_re     = cpu_rd_en && cpu_in_win;
    vid_ex_re  = vid_rd_en && (src == SRC_EXRAM);
    fill_en    = vid_rd_en && (src == SRC_FILL);
  end

  logic [7:0] ex_vid_q, ex_cpu_q, fill_q;

  nts_exram #(.AW(EXRAM_AW)) u_exram (
    .clk(clk), .we(ex_we), .waddr(cpu_off), .wdata(cpu_wdata),
    .re_a(vid_ex_re), .addr_a(vid_off), .q_a(ex_vid_q),
    .re_b(cpu_re), .addr_b(cpu_off), .q_b(ex_cpu_q)
  );

  nts_fill #(.OFF_W(EXRAM_AW), .ATTR_BYTES(ATTR_BYTES)) u_fill (
    .clk(clk), .rst_n(rst_sync_n), .en(fill_en), .offset(vid_off),
    .tile(tile_q), .attr(attr_q), .q(fill_q)
  );

  // output steering state
  own_sel_e own_d, own_q;
  logic     cpu_hit_d, cpu_hit_q;

  always_comb begin
    if (fill_en)        own_d = OWN_FILL;
    else if (vid_ex_re) own_d = OWN_EXRAM;
    else                own_d = OWN_NONE;
    cpu_hit_d = cpu_re;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      own_q     <= OWN_NONE;
      cpu_hit_q <= 1'b0;
    end else begin
      own_q     <= own_d;
      cpu_hit_q <= cpu_hit_d;
    end
  end

  always_comb begin
    vid_rvalid = (own_q != OWN_NONE);
    unique case (own_q)
      OWN_EXRAM: vid_rdata = ex_vid_q;
      OWN_FILL:  vid_rdata = fill_q;
      default:   vid_rdata = 8'h00;
    endcase
    cpu_rdata = cpu_hit_q ? ex_cpu_q : 8'h00;
  end

endmodule

// File: rtl/nt_quad_select_chk.sv
module nt_quad_select_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_rd_en,
  input logic [7:0] cpu_rdata,
  input logic       vid_rd_en,
  input logic       vid_int_en,
  input logic       vid_int_a10,
  input logic       vid_rvalid,
  input logic [7:0] vid_rdata
);

  // R11
  int_en_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_int_en |-> vid_rd_en);

  // R7
  a10_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_int_en |-> !vid_int_a10);

  // R3
  int_then_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_int_en |=> !vid_rvalid);

  // R11
  idle_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_rd_en |=> !vid_rvalid);

  // R3
  data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_rvalid |-> (vid_rdata == 8'h00));

  // R8
  cpu_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd_en |=> (cpu_rdata == 8'h00));

endmodule

bind nt_quad_select nt_quad_select_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rd_en(cpu_rd_en), .cpu_rdata(cpu_rdata),
  .vid_rd_en(vid_rd_en), .vid_int_en(vid_int_en), .vid_int_a10(vid_int_a10),
  .vid_rvalid(vid_rvalid), .vid_rdata(vid_rdata)
);

// File: tb/nt_quad_select_test.sv
module nt_quad_select_test;

  logic        clk;
  logic        rst_n;
  logic        cpu_wr_en, cpu_rd_en;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        vid_rd_en;
  logic [11:0] vid_addr;
  logic        vid_int_en, vid_int_a10, vid_rvalid;
  logic [7:0]  vid_rdata;

  nt_quad_select uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .vid_rd_en(vid_rd_en), .vid_addr(vid_addr), .vid_int_en(vid_int_en),
    .vid_int_a10(vid_int_a10), .vid_rvalid(vid_rvalid), .vid_rdata(vid_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  // reference model state
  int   m_map, m_tile, m_attr;
  int   m_ex [1024];
  int   e_rvalid, e_rdata, e_cpu;
  string e_tag  = "R1";
  string e_ctag = "R1";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // one clock cycle of stimulus, checked against the model
  task automatic step(bit cw, bit cr, int ca, int cd, bit vr, int va, string tag);
    int code, off, q;
    int x_int, x_a10;
    @(negedge clk);
    chk(e_tag,  "vid_rvalid", {31'd0, vid_rvalid}, e_rvalid);
    chk(e_tag,  "vid_rdata",  {24'd0, vid_rdata},  e_rdata);
    chk(e_ctag, "cpu_rdata",  {24'd0, cpu_rdata},  e_cpu);
    cpu_wr_en = cw; cpu_rd_en = cr; cpu_addr = ca[15:0]; cpu_wdata = cd[7:0];
    vid_rd_en = vr; vid_addr = va[11:0];
    #1;
    q    = (va >> 10) & 3;
    off  = va & 1023;
    code = (m_map >> (2 * q)) & 3;
    x_int = (vr && code < 2) ? 1 : 0;
    x_a10 = (x_int == 1 && code == 1) ? 1 : 0;
    chk(tag, "vid_int_en",  {31'd0, vid_int_en},  x_int);
    chk(tag, "vid_int_a10", {31'd0, vid_int_a10}, x_a10);
    // registered results, computed from the state before this edge
    e_tag = tag; e_ctag = tag;
    if (vr && code == 2) begin
      e_rvalid = 1; e_rdata = m_ex[off];
    end else if (vr && code == 3) begin
      e_rvalid = 1;
      e_rdata  = (off >= 960) ? (m_attr * 8'h55) : m_tile;
    end else begin
      e_rvalid = 0; e_rdata = 0;
    end
    if (cr && ca >= 'h5C00 && ca <= 'h5FFF) e_cpu = m_ex[ca - 'h5C00];
    else                                    e_cpu = 0;
    if (cw) begin
      if (ca >= 'h5C00 && ca <= 'h5FFF) m_ex[ca - 'h5C00] = cd & 255;
      else if (ca == 'h5105)            m_map  = cd & 255;
      else if (ca == 'h5106)            m_tile = cd & 255;
      else if (ca == 'h5107)            m_attr = cd & 3;
    end
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic cpu_wr(int a, int d, string tag);
    step(1, 0, a, d, 0, 0, tag);
  endtask

  task automatic cpu_rd(int a, string tag);
    step(0, 1, a, 0, 0, 0, tag);
  endtask

  task automatic vrd(int q, int off, string tag);
    step(0, 0, 0, 0, 1, (q << 10) | off, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    m_map = 0; m_tile = 0; m_attr = 0;
    e_rvalid = 0; e_rdata = 0; e_cpu = 0;
    for (int i = 0; i < 1024; i++) m_ex[i] = 0;
    cpu_wr_en = 0; cpu_rd_en = 0; cpu_addr = 0; cpu_wdata = 0;
    vid_rd_en = 0; vid_addr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: outputs quiet through the reset release
    repeat (4) idle("R1");
    // R1: every quadrant maps to page 0 after reset
    for (int q = 0; q < 4; q++) vrd(q, 16 * q, "R1");
    idle("R1");

    // fill the extended RAM through the CPU window (R8)
    for (int i = 0; i < 1024; i++) cpu_wr('h5C00 + i, (i * 7 + 3) & 255, "R8");
    cpu_rd('h5C00, "R8");
    cpu_rd('h5FFF, "R8");
    cpu_wr('h6000, 'hC3, "R8");
    cpu_wr('h5BFF, 'hC3, "R8");
    cpu_rd('h5C00, "R8");
    cpu_rd('h5FFF, "R8");
    cpu_rd('h6000, "R8");
    cpu_rd('h5BFF, "R8");

    // R9: same-cycle write uses the old mapping, then the new one
    step(1, 0, 'h5105, 'hE4, 1, (1 << 10) | 5, "R9");
    vrd(1, 5, "R9");
    // R2: quadrant n decodes bits [2n+1:2n] of 0xE4 -> 0,1,2,3
    for (int q = 0; q < 4; q++) vrd(q, 'h123, "R2");
    idle("R2");
    // R3: both pages
    vrd(0, 'h3FF, "R3");
    vrd(1, 'h000, "R3");
    idle("R3");

    // R5 / R6: fill tile and attribute areas
    cpu_wr('h5106, 'h5A, "R9");
    cpu_wr('h5107, 'hFE, "R9");
    vrd(3, 'h000, "R5");
    vrd(3, 'h3BF, "R5");
    vrd(3, 'h3C0, "R6");
    vrd(3, 'h3FF, "R6");
    // R9: fill changes picked up on the very next access
    step(1, 0, 'h5107, 'h01, 1, (3 << 10) | 'h3D0, "R9");
    vrd(3, 'h3D0, "R6");
    step(1, 0, 'h5106, 'hA7, 1, (3 << 10) | 'h010, "R9");
    vrd(3, 'h010, "R5");
    idle("R5");

    // R4: extended RAM reads
    vrd(2, 'h000, "R4");
    vrd(2, 'h3FF, "R4");
    vrd(2, 'h1A5, "R4");
    idle("R4");

    // R10: collision returns old byte, then new byte
    step(1, 0, 'h5C10, 'h77, 1, (2 << 10) | 'h010, "R10");
    vrd(2, 'h010, "R10");
    idle("R10");

    // R7: all fill, then all extended RAM, no page enable
    cpu_wr('h5105, 'hFF, "R7");
    for (int q = 0; q < 4; q++) vrd(q, 'h3C1 - q, "R7");
    cpu_wr('h5105, 'hAA, "R7");
    for (int q = 0; q < 4; q++) vrd(q, 'h22 * q, "R7");
    // R3: all page 1
    cpu_wr('h5105, 'h55, "R3");
    for (int q = 0; q < 4; q++) vrd(q, 'h40 + q, "R3");
    // R11: idle after traffic
    idle("R11");
    idle("R11");

    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      int sel, ca, cd, va;
      bit cw, cr, vr;
      sel = $urandom_range(0, 9);
      cd  = $urandom_range(0, 255);
      case (sel)
        0: ca = 'h5105;
        1: ca = 'h5106;
        2: ca = 'h5107;
        3: ca = 'h6000 + $urandom_range(0, 255);
        default: ca = 'h5C00 + $urandom_range(0, 1023);
      endcase
      cw = ($urandom_range(0, 2) == 0);
      cr = !cw && ($urandom_range(0, 1) == 1);
      vr = ($urandom_range(0, 3) != 0);
      va = $urandom_range(0, 4095);
      if ($urandom_range(0, 3) == 0) va = (va & 'hC00) | ('h3BE + $urandom_range(0, 3));
      step(cw, cr, ca, cd, vr, va, "R2");
    end
    idle("R11");
    idle("R11");
    summary();
  end

endmodule